// File: doc/BRIEF.md
# Self-Routing Banyan Switch Fabric

This block moves fixed-size packets from N input ports to N output ports through a multistage shuffle-exchange network of 2x2 switching elements. Each packet carries its own output address. No central controller exists: every element looks at a single address bit and sends the packet up or down, so the route is fixed by the address alone. When two packets meet at an element and both ask for the same outgoing link, one of them is thrown away. The fabric is a loss system. It has no buffers, no speedup and no retry.

Every clock cycle, the surrounding logic presents a slot of packets, one per input port, each with a valid flag, an address and a payload. One cycle later, each output port shows the packet that reached it, along with the index of the input it came from. Each input also gets a delivered flag or a dropped flag, so the source can decide whether to resend in a later slot. N must be a power of two. The address width is log2 N.

Top module: `banyan_fabric`

## Requirements
- R1: The fabric has log2 N stages. Before each stage, packet positions pass through a perfect shuffle, which rotates the position index left by one bit. A packet that survives every stage leaves on the output port whose index equals its address, with its own payload and its input index on the source field.
- R2: Stage s (stage 0 is the first) steers on address bit log2N-1-s. A 0 on that bit selects the element's upper output (even position). A 1 selects the lower output (odd position).
- R3: When both inputs of an element carry valid packets that select the same output, the packet on the upper input (even position) passes and the packet on the lower input is dropped. This covers internal link clashes and final-port clashes alike.
- R4: An idle input (valid low) never clashes with another packet, never shows up as valid on any output, and is flagged neither delivered nor dropped, whatever its address and payload hold.
- R5: For one slot, every valid input is flagged either delivered or dropped, and never both.
- R6: In every stage, the number of valid packets leaving plus the number dropped equals the number of valid packets entering.
- R7: Outputs and status flags are registered. They show the result of the slot presented one clock edge earlier. An active-low reset clears all of them to zero.
- R8: Distinct destinations do not guarantee delivery. A full slot whose addresses are the bit-reversal of the input indices (N=8) loses packets, while the identity mapping delivers all of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N | Per-input packet present flag |
| in_dest | input | N x log2N | Per-input destination address |
| in_data | input | N x DATA_W | Per-input payload |
| out_valid | output | N | Per-output packet delivered flag |
| out_data | output | N x DATA_W | Per-output payload |
| out_src | output | N x log2N | Input index of the delivered packet |
| delivered | output | N | Per-input: packet reached its output |
| dropped | output | N | Per-input: packet lost in a clash |

## Verification
Some checks run on every cycle. These cover the steering bit of each valid packet at every stage, packet conservation across each stage, silence of a stage that receives no packets, the exclusive and complete delivered/dropped accounting, and the rule that each delivered packet sits on the port named by its address with its own payload. What no per-cycle property can show is which packet loses a given clash. That includes upper-input priority, the loss pattern under bit-reversal compared with identity, and the one-cycle register timing. These are shown by the bench's directed slots and random slots, checked against a position-tracking model.

// File: rtl/banyan_pkg.sv
package banyan_pkg;

  // Perfect shuffle on an lg-bit position: rotate left by one bit.
  function automatic int shuffle_pos(int p, int lg);
    int mask;
    mask = (1 << lg) - 1;
    return ((p << 1) | (p >> (lg - 1))) & mask;
  endfunction

  // Address bit that steers a packet in a given stage (MSB first).
  function automatic int steer_bit(int stage, int lg);
    return lg - 1 - stage;
  endfunction

endpackage

// File: rtl/banyan_elem.sv
module banyan_elem #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int BIT    = 0
) (
  input  logic              u_v,
  input  logic [ADDR_W-1:0] u_dest,
  input  logic [ADDR_W-1:0] u_src,
  input  logic [DATA_W-1:0] u_data,
  input  logic              l_v,
  input  logic [ADDR_W-1:0] l_dest,
  input  logic [ADDR_W-1:0] l_src,
  input  logic [DATA_W-1:0] l_data,
  output logic              o0_v,
  output logic [ADDR_W-1:0] o0_dest,
  output logic [ADDR_W-1:0] o0_src,
  output logic [DATA_W-1:0] o0_data,
  output logic              o1_v,
  output logic [ADDR_W-1:0] o1_dest,
  output logic [ADDR_W-1:0] o1_src,
  output logic [DATA_W-1:0] o1_data,
  output logic              lose,
  output logic [ADDR_W-1:0] lose_src
);

  logic u_low, l_low, u_up, l_up;

  always_comb begin
    // a packet heads up on bit 0, down on bit 1
    u_up  = u_v & ~u_dest[BIT];
    u_low = u_v &  u_dest[BIT];
    l_up  = l_v & ~l_dest[BIT];
    l_low = l_v &  l_dest[BIT];

    // upper input has priority on either link
    o0_v    = u_up | l_up;
    o0_dest = u_up ? u_dest : l_dest;
    o0_src  = u_up ? u_src  : l_src;
    o0_data = u_up ? u_data : l_data;

    o1_v    = u_low | l_low;
    o1_dest = u_low ? u_dest : l_dest;
    o1_src  = u_low ? u_src  : l_src;
    o1_data = u_low ? u_data : l_data;

    lose     = (u_up & l_up) | (u_low & l_low);
    lose_src = l_src;
  end

endmodule

// File: rtl/banyan_stage.sv
module banyan_stage
  import banyan_pkg::*;
#(
  parameter int N      = 8,
  parameter int DATA_W = 16,
  parameter int STAGE  = 0,
  localparam int ADDR_W = $clog2(N),
  localparam int HALF   = N / 2,
  localparam int BIT    = ADDR_W - 1 - STAGE
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N-1:0]                 in_v,
  input  logic [N-1:0][ADDR_W-1:0]     in_dest,
  input  logic [N-1:0][ADDR_W-1:0]     in_src,
  input  logic [N-1:0][DATA_W-1:0]     in_data,
  output logic [N-1:0]                 out_v,
  output logic [N-1:0][ADDR_W-1:0]     out_dest,
  output logic [N-1:0][ADDR_W-1:0]     out_src,
  output logic [N-1:0][DATA_W-1:0]     out_data,
  output logic [HALF-1:0]              lose,
  output logic [HALF-1:0][ADDR_W-1:0]  lose_src
);

  logic [N-1:0]             sh_v;
  logic [N-1:0][ADDR_W-1:0] sh_dest;
  logic [N-1:0][ADDR_W-1:0] sh_src;
  logic [N-1:0][DATA_W-1:0] sh_data;

  // perfect-shuffle wiring into the element column
  for (genvar p = 0; p < N; p++) begin : g_shuf
    localparam int Q = shuffle_pos(p, ADDR_W);
    assign sh_v[Q]    = in_v[p];
    assign sh_dest[Q] = in_dest[p];
    assign sh_src[Q]  = in_src[p];
    assign sh_data[Q] = in_data[p];
  end

  for (genvar j = 0; j < HALF; j++) begin : g_elem
    banyan_elem #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BIT    (steer_bit(STAGE, ADDR_W))
    ) u_elem (
      .u_v      (sh_v[2*j]),
      .u_dest   (sh_dest[2*j]),
      .u_src    (sh_src[2*j]),
      .u_data   (sh_data[2*j]),
      .l_v      (sh_v[2*j+1]),
      .l_dest   (sh_dest[2*j+1]),
      .l_src    (sh_src[2*j+1]),
      .l_data   (sh_data[2*j+1]),
      .o0_v     (out_v[2*j]),
      .o0_dest  (out_dest[2*j]),
      .o0_src   (out_src[2*j]),
      .o0_data  (out_data[2*j]),
      .o1_v     (out_v[2*j+1]),
      .o1_dest  (out_dest[2*j+1]),
      .o1_src   (out_src[2*j+1]),
      .o1_data  (out_data[2*j+1]),
      .lose     (lose[j]),
      .lose_src (lose_src[j])
    );
  end

  // R6: packets leaving plus packets lost equals packets entering
  assert_conserve_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(out_v) + $countones(lose)) == $countones(in_v));

  // R4: an empty stage produces nothing and loses nothing
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v == '0) |-> ((out_v == '0) && (lose == '0)));

  // R2: a valid packet on position p carries steering bit equal to p's LSB
  for (genvar p = 0; p < N; p++) begin : g_chk
    assert_steer_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_v[p] |-> (out_dest[p][BIT] == 1'(p % 2)));
  end

endmodule

// File: rtl/banyan_fabric.sv
module banyan_fabric #(
  parameter int N      = 8,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(N),
  localparam int HALF   = N / 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             in_valid,
  input  logic [N-1:0][ADDR_W-1:0] in_dest,
  input  logic [N-1:0][DATA_W-1:0] in_data,
  output logic [N-1:0]             out_valid,
  output logic [N-1:0][DATA_W-1:0] out_data,
  output logic [N-1:0][ADDR_W-1:0] out_src,
  output logic [N-1:0]             delivered,
  output logic [N-1:0]             dropped
);

  initial assert ((1 << ADDR_W) == N && N >= 2)
    else $error("N must be a power of two of at least 2");

  logic [ADDR_W:0][N-1:0]                 st_v;
  logic [ADDR_W:0][N-1:0][ADDR_W-1:0]     st_dest;
  logic [ADDR_W:0][N-1:0][ADDR_W-1:0]     st_src;
  logic [ADDR_W:0][N-1:0][DATA_W-1:0]     st_data;
  logic [ADDR_W-1:0][HALF-1:0]            st_lose;
  logic [ADDR_W-1:0][HALF-1:0][ADDR_W-1:0] st_lose_src;

  logic [N-1:0] dlv_d;
  logic [N-1:0] drp_d;

  assign st_v[0]    = in_valid;
  assign st_dest[0] = in_dest;
  assign st_data[0] = in_data;
  for (genvar i = 0; i < N; i++) begin : g_tag
    assign st_src[0][i] = ADDR_W'(i);
  end

  for (genvar s = 0; s < ADDR_W; s++) begin : g_stage
    banyan_stage #(
      .N      (N),
      .DATA_W (DATA_W),
      .STAGE  (s)
    ) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_v     (st_v[s]),
      .in_dest  (st_dest[s]),
      .in_src   (st_src[s]),
      .in_data  (st_data[s]),
      .out_v    (st_v[s+1]),
      .out_dest (st_dest[s+1]),
      .out_src  (st_src[s+1]),
      .out_data (st_data[s+1]),
      .lose     (st_lose[s]),
      .lose_src (st_lose_src[s])
    );
  end

  // per-input status gathered from clash reports and final positions
  always_comb begin
    drp_d = '0;
    dlv_d = '0;
    for (int s = 0; s < ADDR_W; s++) begin
      for (int j = 0; j < HALF; j++) begin
        if (st_lose[s][j]) drp_d[st_lose_src[s][j]] = 1'b1;
      end
    end
    for (int p = 0; p < N; p++) begin
      if (st_v[ADDR_W][p]) dlv_d[st_src[ADDR_W][p]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_data  <= '0;
      out_src   <= '0;
      delivered <= '0;
      dropped   <= '0;
    end else begin
      out_valid <= st_v[ADDR_W];
      out_data  <= st_data[ADDR_W];
      out_src   <= st_src[ADDR_W];
      delivered <= dlv_d;
      dropped   <= drp_d;
    end
  end

  // R5: no input both delivered and dropped
  assert_status_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_d & drp_d) == '0);

  // R5/R4: exactly the valid inputs are accounted for
  assert_status_cover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_d | drp_d) == in_valid);

  // R1: each surviving packet exits on its own address with its own payload
  for (genvar p = 0; p < N; p++) begin : g_exit
    assert_exit_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
      st_v[ADDR_W][p] |-> (in_dest[st_src[ADDR_W][p]] == ADDR_W'(p)));
    assert_exit_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
      st_v[ADDR_W][p] |-> (in_data[st_src[ADDR_W][p]] == st_data[ADDR_W][p]));
  end

endmodule

// File: tb/banyan_fabric_tb.sv
`timescale 1ns/1ps
module banyan_fabric_tb;

  localparam int N  = 8;
  localparam int DW = 16;
  localparam int LG = $clog2(N);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [N-1:0]         in_valid;
  logic [N-1:0][LG-1:0] in_dest;
  logic [N-1:0][DW-1:0] in_data;
  logic [N-1:0]         out_valid;
  logic [N-1:0][DW-1:0] out_data;
  logic [N-1:0][LG-1:0] out_src;
  logic [N-1:0]         delivered;
  logic [N-1:0]         dropped;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // stimulus and expected results
  logic [N-1:0] stim_v;
  int           stim_dest [N];
  int           stim_data [N];
  logic [N-1:0] exp_ov;
  int           exp_src  [N];
  int           exp_dat  [N];
  logic [N-1:0] exp_dlv;
  logic [N-1:0] exp_drp;

  always #4 clk = ~clk;

  banyan_fabric #(.N(N), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_src(out_src), .delivered(delivered), .dropped(dropped)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // position-tracking model: shuffle by arithmetic, element pairs, lower loses
  task automatic run_model();
    int  pos [N];
    bit  alive [N];
    int  shp [N];
    int  np [N];
    int  loser;
    exp_ov = '0; exp_dlv = '0; exp_drp = '0;
    for (int i = 0; i < N; i++) begin
      pos[i] = i; alive[i] = stim_v[i]; exp_src[i] = 0; exp_dat[i] = 0;
    end
    for (int s = 0; s < LG; s++) begin
      for (int i = 0; i < N; i++) begin
        shp[i] = ((pos[i] * 2) % N) + (pos[i] / (N / 2));
        np[i]  = (shp[i] / 2) * 2 + ((stim_dest[i] >> (LG - 1 - s)) & 1);
      end
      for (int i = 0; i < N; i++) begin
        for (int k = i + 1; k < N; k++) begin
          if (alive[i] && alive[k] && np[i] == np[k]) begin
            loser = (shp[i] % 2 == 1) ? i : k;
            alive[loser] = 0;
            exp_drp[loser] = 1'b1;
          end
        end
      end
      for (int i = 0; i < N; i++) pos[i] = np[i];
    end
    for (int i = 0; i < N; i++) begin
      if (alive[i]) begin
        exp_ov[pos[i]] = 1'b1;
        exp_src[pos[i]] = i;
        exp_dat[pos[i]] = stim_data[i];
        exp_dlv[i] = 1'b1;
      end
    end
  endtask

  // drive at a falling edge, compare one cycle later at the next falling edge
  task automatic apply(input string req);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      in_valid[i] = stim_v[i];
      in_dest[i]  = LG'(stim_dest[i]);
      in_data[i]  = DW'(stim_data[i]);
    end
    run_model();
    @(negedge clk);
    check(out_valid == exp_ov, req, "out_valid", out_valid, exp_ov);
    for (int p = 0; p < N; p++) begin
      if (exp_ov[p]) begin
        check(out_src[p] == LG'(exp_src[p]), req, "out_src", out_src[p], exp_src[p]);
        check(out_data[p] == DW'(exp_dat[p]), req, "out_data", out_data[p], exp_dat[p]);
      end
    end
    check(delivered == exp_dlv, req, "delivered", delivered, exp_dlv);
    check(dropped == exp_drp, req, "dropped", dropped, exp_drp);
  endtask

  task automatic clear_stim();
    stim_v = '0;
    for (int i = 0; i < N; i++) begin
      stim_dest[i] = 0; stim_data[i] = 0;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    in_valid = '0; in_dest = '0; in_data = '0;
    clear_stim();
    repeat (3) @(negedge clk);
    // R7: reset clears every output
    check(out_valid == '0 && delivered == '0 && dropped == '0 && out_data == '0
          && out_src == '0, "R7", "reset outputs", out_valid, 0);
    rst_n = 1'b1;

    // R4: all idle, garbage on address and payload
    clear_stim();
    for (int i = 0; i < N; i++) begin stim_dest[i] = 7 - i; stim_data[i] = 16'hA000 + i; end
    apply("R4");

    // R1/R2: single packet 3 -> 5
    clear_stim();
    stim_v[3] = 1'b1; stim_dest[3] = 5; stim_data[3] = 16'h1234;
    apply("R1");
    check(out_valid[5] && out_src[5] == 3, "R2", "single path port", out_src[5], 3);

    // R3: inputs 0 and 4 meet in the first element, upper (input 0) wins
    clear_stim();
    stim_v[0] = 1'b1; stim_dest[0] = 1; stim_data[0] = 16'h00AA;
    stim_v[4] = 1'b1; stim_dest[4] = 0; stim_data[4] = 16'h00BB;
    apply("R3");
    check(dropped[4] && delivered[0], "R3", "upper wins", {dropped, delivered}, 16'h1001);

    // R3: every input aims at port 6, exactly one survives
    clear_stim();
    for (int i = 0; i < N; i++) begin stim_v[i] = 1'b1; stim_dest[i] = 6; stim_data[i] = 100 + i; end
    apply("R3");
    check($countones(delivered) == 1, "R3", "single winner", $countones(delivered), 1);

    // R8: identity delivers all
    clear_stim();
    for (int i = 0; i < N; i++) begin stim_v[i] = 1'b1; stim_dest[i] = i; stim_data[i] = 16'h5000 + i; end
    apply("R8");
    check(delivered == '1, "R8", "identity all delivered", delivered, 8'hFF);

    // R7: new slot driven, outputs hold the old slot until the clock edge
    @(negedge clk);
    in_valid = '0;
    #1;
    check(out_valid == '1, "R7", "hold before edge", out_valid, 8'hFF);
    @(negedge clk);
    check(out_valid == '0, "R7", "update after edge", out_valid, 0);

    // R8: bit-reversal with distinct destinations still loses packets
    clear_stim();
    for (int i = 0; i < N; i++) begin
      stim_v[i] = 1'b1;
      stim_dest[i] = ((i & 1) << 2) | (i & 2) | ((i >> 2) & 1);
      stim_data[i] = 16'h7000 + i;
    end
    apply("R8");
    check(dropped != '0, "R8", "bit-reversal blocks", dropped, 1);

    // R4/R5: half idle with addresses that would clash if counted
    clear_stim();
    for (int i = 0; i < N; i++) begin
      stim_v[i] = (i % 2 == 0); stim_dest[i] = 2; stim_data[i] = i;
    end
    stim_dest[0] = 0; stim_dest[2] = 3; stim_dest[4] = 5; stim_dest[6] = 7;
    apply("R4");
    check((delivered | dropped) == 8'h55, "R5", "accounting", delivered | dropped, 8'h55);

    // random slots
    for (int t = 0; t < 400; t++) begin
      for (int i = 0; i < N; i++) begin
        stim_v[i]    = ($urandom % 4) != 0;
        stim_dest[i] = $urandom % N;
        stim_data[i] = $urandom % 65536;
      end
      apply("R1");
      check(($countones(delivered) + $countones(dropped)) == $countones(stim_v)
            && (delivered & dropped) == '0, "R6", "conservation",
            $countones(delivered) + $countones(dropped), $countones(stim_v));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule